// File: doc/BRIEF.md
# DMA Width-Converting Staging Buffer

This block is the holding stage of a DMA channel that moves data in two bus cycles: a read from the source side, then a write to the destination side. It keeps up to four bytes. A pass has two phases. In the fill phase it asks the sequencer for read cycles and packs the returned bytes into the buffer. In the drain phase it asks for write cycles and unpacks the bytes onto the destination bus. The requester side and the target side are each 8 or 16 bits wide, chosen independently. A direction input selects which side is read and which side is written. Memory and I/O are treated alike.

At the start of a pass the sequencer gives the remaining byte count. The block takes the smaller of that count and four as the size of the pass. It reports how many read and write cycles the pass needs. It emits one-clock pulses when the fill ends and when the drain ends, so the sequencer can update its count and its addresses. Address generation and bus signalling are outside this block. Each requested cycle ends when the sequencer returns a one-clock acknowledge.

Top module: `dma_stage_buf`

## Requirements
- R1: A start with a byte count of zero, or a start while busy, is ignored. State, cycle counts and the pass in progress do not change.
- R2: From the cycle after an accepted start until the pass ends, rd_cycles equals the pass size N = min(bytes_left, 4) for an 8-bit source and ceil(N/2) for a 16-bit source. wr_cycles follows the same rule using the destination width.
- R3: rd_req is high from the cycle after an accepted start until the final read acknowledge. wr_req is never high together with rd_req. Exactly rd_cycles read acknowledges complete the fill.
- R4: A 16-bit source read stores two bytes: rd_data[7:0] first, then rd_data[15:8]. When only one byte of the pass is left to read, a 16-bit read stores rd_data[7:0] alone. An 8-bit read always stores rd_data[7:0].
- R5: With dir_t2r = 0 the requester side (req_wide) is the source and the target side (tgt_wide) is the destination. With dir_t2r = 1 the roles are swapped. Each width input is 1 for 16 bits and 0 for 8 bits.
- R6: fill_done is high for exactly one clock, in the cycle after the final read acknowledge. wr_req is already high in that cycle.
- R7: Bytes are written in the order they arrived. An 8-bit destination gets one byte on wr_data[7:0], with wr_data[15:8] = 0 and wr_be = 01. A 16-bit destination gets the earlier byte on the low lane and the later byte on the high lane, with wr_be = 11. A single leftover byte uses wr_be = 01 and zero on the high lane.
- R8: drain_done is high for exactly one clock, in the cycle after the final write acknowledge. In that cycle busy and wr_req are low.
- R9: A read acknowledge outside the fill phase, and a write acknowledge outside the drain phase, have no effect.
- R10: After reset the block is idle: busy, rd_req, wr_req, fill_done and drain_done are low, rd_cycles and wr_cycles are 0, and wr_be is 00.
- R11: A four-byte pass from an 8-bit source to a 16-bit destination takes four read cycles and two write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass when idle |
| bytes_left | input | CNT_W | Bytes remaining in the buffer transfer, sampled at start |
| req_wide | input | 1 | Requester side is 16 bits wide |
| tgt_wide | input | 1 | Target side is 16 bits wide |
| dir_t2r | input | 1 | 1: target is the source; 0: requester is the source |
| rd_ack | input | 1 | Read cycle complete, rd_data valid |
| rd_data | input | 16 | Data from the source bus |
| wr_ack | input | 1 | Write cycle complete |
| busy | output | 1 | A pass is in progress |
| rd_req | output | 1 | Read cycle requested |
| wr_req | output | 1 | Write cycle requested |
| wr_data | output | 16 | Data for the destination bus |
| wr_be | output | 2 | Byte lane enables for the write |
| rd_cycles | output | PTR_W | Read cycles needed for this pass |
| wr_cycles | output | PTR_W | Write cycles needed for this pass |
| fill_done | output | 1 | One-clock pulse at the end of the fill phase |
| drain_done | output | 1 | One-clock pulse at the end of the drain phase |

## Verification
The hardest case to reach from the ports is a pass of odd size whose source and destination widths differ. There, a 16-bit read or write covers one byte while the neighbouring cycles cover two, and the pointer and the lane enables have to agree. The random passes draw the byte count heavily from one to four and choose each width and the direction independently, so every mix of odd tails and width pairs appears many times. Stray acknowledges in the wrong phase, and a start issued in the middle of a fill, are injected among these passes. This shows that only the planned cycles move the buffer.

// File: rtl/dma_stg_pkg.sv
package dma_stg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } stg_state_e;
endpackage

// File: rtl/stg_plan.sv
module stg_plan #(
  parameter int CNT_W     = 16,
  parameter int BUF_BYTES = 4,
  parameter int PTR_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic [CNT_W-1:0] bytes_left,
  input  logic             req_wide,
  input  logic             tgt_wide,
  input  logic             dir_t2r,
  output logic             src_wide,
  output logic             dst_wide,
  output logic [PTR_W-1:0] chunk,
  output logic [PTR_W-1:0] rd_cyc,
  output logic [PTR_W-1:0] wr_cyc
);
  always_comb begin
    src_wide = dir_t2r ? tgt_wide : req_wide;
    dst_wide = dir_t2r ? req_wide : tgt_wide;
    if (bytes_left >= CNT_W'(BUF_BYTES)) chunk = PTR_W'(BUF_BYTES);
    else                                 chunk = bytes_left[PTR_W-1:0];
    rd_cyc = src_wide ? ((chunk + PTR_W'(1)) >> 1) : chunk;
    wr_cyc = dst_wide ? ((chunk + PTR_W'(1)) >> 1) : chunk;
  end
endmodule

// File: rtl/stg_store.sv
module stg_store #(
  parameter int BUF_BYTES = 4,
  parameter int PTR_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   load,
  input  logic                   src_wide,
  input  logic [PTR_W-1:0]       chunk,
  input  logic [15:0]            rd_data,
  output logic [BUF_BYTES*8-1:0] buf_flat,
  output logic                   fill_last
);
  logic [PTR_W-1:0] cnt_q, cnt_d, left, take;

  always_comb begin
    left      = chunk - cnt_q;
    take      = (src_wide && left >= PTR_W'(2)) ? PTR_W'(2) : PTR_W'(1);
    fill_last = load && ((cnt_q + take) == chunk);
    cnt_d     = cnt_q;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = cnt_q + take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr || load)   cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_slot
    logic [7:0] slot_q, slot_d;
    logic       slot_en;
    always_comb begin
      slot_en = 1'b0;
      slot_d  = slot_q;
      if (load && cnt_q == PTR_W'(g)) begin
        slot_en = 1'b1;
        slot_d  = rd_data[7:0];
      end else if (load && take == PTR_W'(2) && (cnt_q + PTR_W'(1)) == PTR_W'(g)) begin
        slot_en = 1'b1;
        slot_d  = rd_data[15:8];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end
    assign buf_flat[g*8 +: 8] = slot_q;
  end

  // R4: the fill pointer never runs past the pass size
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= chunk);
endmodule

// File: rtl/stg_drain.sv
module stg_drain #(
  parameter int BUF_BYTES = 4,
  parameter int PTR_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   adv,
  input  logic                   dst_wide,
  input  logic [PTR_W-1:0]       chunk,
  input  logic [BUF_BYTES*8-1:0] buf_flat,
  output logic [15:0]            data,
  output logic [1:0]             be,
  output logic                   drain_last
);
  logic [PTR_W-1:0] ptr_q, ptr_d, left, give;
  logic [7:0]       lo_b, hi_b;

  always_comb begin
    left = chunk - ptr_q;
    give = (dst_wide && left >= PTR_W'(2)) ? PTR_W'(2) : PTR_W'(1);
    lo_b = '0;
    hi_b = '0;
    for (int i = 0; i < BUF_BYTES; i++) begin
      if (ptr_q == PTR_W'(i))                lo_b = buf_flat[i*8 +: 8];
      if ((ptr_q + PTR_W'(1)) == PTR_W'(i))  hi_b = buf_flat[i*8 +: 8];
    end
    if (give == PTR_W'(2)) begin
      data = {hi_b, lo_b};
      be   = 2'b11;
    end else begin
      data = {8'h00, lo_b};
      be   = 2'b01;
    end
    drain_last = adv && ((ptr_q + give) == chunk);
    ptr_d = ptr_q;
    if (clr)      ptr_d = '0;
    else if (adv) ptr_d = ptr_q + give;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr_q <= '0;
    else if (clr || adv) ptr_q <= ptr_d;
  end

  // R7: the drain pointer never runs past the pass size
  p_drain_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= chunk);
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf
  import dma_stg_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BUF_BYTES = 4,
  parameter int PTR_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] bytes_left,
  input  logic             req_wide,
  input  logic             tgt_wide,
  input  logic             dir_t2r,
  input  logic             rd_ack,
  input  logic [15:0]      rd_data,
  input  logic             wr_ack,
  output logic             busy,
  output logic             rd_req,
  output logic             wr_req,
  output logic [15:0]      wr_data,
  output logic [1:0]       wr_be,
  output logic [PTR_W-1:0] rd_cycles,
  output logic [PTR_W-1:0] wr_cycles,
  output logic             fill_done,
  output logic             drain_done
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  stg_state_e       st_q, st_d;
  logic             take_start, load, adv, fill_last, drain_last;
  logic             p_src_w, p_dst_w;
  logic [PTR_W-1:0] p_chunk, p_rd, p_wr;
  logic             srcw_q, dstw_q;
  logic [PTR_W-1:0] chunk_q, rdc_q, wrc_q;
  logic             fdone_q, fdone_d, ddone_q, ddone_d;
  logic [BUF_BYTES*8-1:0] buf_flat;
  logic [15:0]      drn_data;
  logic [1:0]       drn_be;

  stg_plan #(.CNT_W(CNT_W), .BUF_BYTES(BUF_BYTES), .PTR_W(PTR_W)) u_plan (
    .bytes_left(bytes_left), .req_wide(req_wide), .tgt_wide(tgt_wide),
    .dir_t2r(dir_t2r), .src_wide(p_src_w), .dst_wide(p_dst_w),
    .chunk(p_chunk), .rd_cyc(p_rd), .wr_cyc(p_wr));

  stg_store #(.BUF_BYTES(BUF_BYTES), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n_s), .clr(take_start), .load(load),
    .src_wide(srcw_q), .chunk(chunk_q), .rd_data(rd_data),
    .buf_flat(buf_flat), .fill_last(fill_last));

  stg_drain #(.BUF_BYTES(BUF_BYTES), .PTR_W(PTR_W)) u_drain (
    .clk(clk), .rst_n(rst_n_s), .clr(take_start), .adv(adv),
    .dst_wide(dstw_q), .chunk(chunk_q), .buf_flat(buf_flat),
    .data(drn_data), .be(drn_be), .drain_last(drain_last));

  always_comb begin
    take_start = (st_q == ST_IDLE) && start && (bytes_left != '0);
    load       = (st_q == ST_FILL) && rd_ack;
    adv        = (st_q == ST_DRAIN) && wr_ack;
    st_d       = st_q;
    fdone_d    = 1'b0;
    ddone_d    = 1'b0;
    case (st_q)
      ST_IDLE:  if (take_start) st_d = ST_FILL;
      ST_FILL:  if (fill_last) begin
                  st_d    = ST_DRAIN;
                  fdone_d = 1'b1;
                end
      ST_DRAIN: if (drain_last) begin
                  st_d    = ST_IDLE;
                  ddone_d = 1'b1;
                end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      fdone_q <= 1'b0;
      ddone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fdone_q <= fdone_d;
      ddone_q <= ddone_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      srcw_q  <= 1'b0;
      dstw_q  <= 1'b0;
      chunk_q <= '0;
      rdc_q   <= '0;
      wrc_q   <= '0;
    end else if (take_start) begin
      srcw_q  <= p_src_w;
      dstw_q  <= p_dst_w;
      chunk_q <= p_chunk;
      rdc_q   <= p_rd;
      wrc_q   <= p_wr;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign rd_req     = (st_q == ST_FILL);
  assign wr_req     = (st_q == ST_DRAIN);
  assign wr_data    = wr_req ? drn_data : 16'h0000;
  assign wr_be      = wr_req ? drn_be : 2'b00;
  assign rd_cycles  = rdc_q;
  assign wr_cycles  = wrc_q;
  assign fill_done  = fdone_q;
  assign drain_done = ddone_q;

  // R3: never read and write in the same cycle
  p_excl_req_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(rd_req && wr_req));
  // R6: fill_done is a single-cycle pulse and drain is already requested
  p_fill_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    fill_done |=> !fill_done);
  p_fill_wr_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    fill_done |-> wr_req);
  // R8: drain_done coincides with idle
  p_drain_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    drain_done |-> (!busy && !wr_req));
  // R1: a start during a pass leaves the planned cycle counts alone
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && start) |=> ($stable(rd_cycles) && $stable(wr_cycles)));
  // R2: a running pass always needs between one and BUF_BYTES cycles
  p_cyc_range_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |-> (rd_cycles != '0 && rd_cycles <= PTR_W'(BUF_BYTES)));
endmodule

// File: tb/sim_dma_stage_buf.sv
`timescale 1ns/1ps
module sim_dma_stage_buf;
  localparam int CNT_W = 16;
  localparam int PTR_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] bytes_left = '0;
  logic             req_wide = 1'b0, tgt_wide = 1'b0, dir_t2r = 1'b0;
  logic             rd_ack = 1'b0, wr_ack = 1'b0;
  logic [15:0]      rd_data = '0;
  logic             busy, rd_req, wr_req, fill_done, drain_done;
  logic [15:0]      wr_data;
  logic [1:0]       wr_be;
  logic [PTR_W-1:0] rd_cycles, wr_cycles;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] exp_b [4];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_stage_buf u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bytes_left(bytes_left),
    .req_wide(req_wide), .tgt_wide(tgt_wide), .dir_t2r(dir_t2r),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_ack(wr_ack),
    .busy(busy), .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
    .wr_be(wr_be), .rd_cycles(rd_cycles), .wr_cycles(wr_cycles),
    .fill_done(fill_done), .drain_done(drain_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int pass_size(input int bl);
    return (bl >= 4) ? 4 : bl;
  endfunction

  function automatic int cyc_need(input int n, input bit wide);
    return wide ? (n + 1) / 2 : n;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // One complete pass with optional stray acknowledges and a mid-fill start
  task automatic run_pass(input int bl, input bit rw, input bit tw, input bit dr,
                          input bit stray, input bit inj_start);
    int n, nrd, nwr, m, fill_pos;
    bit sw, dw;
    logic [15:0] d, ed;
    logic [1:0] eb;
    sw = dr ? tw : rw;   // R5
    dw = dr ? rw : tw;
    n = pass_size(bl);
    nrd = cyc_need(n, sw);
    nwr = cyc_need(n, dw);
    bytes_left = CNT_W'(bl); req_wide = rw; tgt_wide = tw; dir_t2r = dr;
    start = 1'b1;
    tick();
    start = 1'b0;
    if (n == 0) begin
      chk(!busy && !rd_req, "R1 zero count ignored", busy, 0);
      tick();
      chk(!busy, "R1 zero count stays idle", busy, 0);
      return;
    end
    chk(busy && rd_req && !wr_req, "R3 fill requested", {busy, rd_req, wr_req}, 3'b110);
    chk(rd_cycles == PTR_W'(nrd), "R2/R5 rd_cycles", rd_cycles, nrd);
    chk(wr_cycles == PTR_W'(nwr), "R2/R5 wr_cycles", wr_cycles, nwr);
    fill_pos = 0;
    for (int k = 0; k < nrd; k++) begin
      int w = $urandom_range(0, 2);
      if (inj_start && k == 0) begin
        bytes_left = 1; req_wide = !rw; tgt_wide = !tw; dir_t2r = !dr;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(rd_cycles == PTR_W'(nrd) && rd_req, "R1 start while busy", rd_cycles, nrd);
      end
      for (int j = 0; j < w; j++) begin
        if (stray) wr_ack = 1'b1;   // R9 stray write ack in fill
        tick();
        wr_ack = 1'b0;
      end
      chk(rd_req && !wr_req && !fill_done, "R3 fill still open", {rd_req, wr_req, fill_done}, 3'b100);
      d = 16'($urandom);
      rd_data = d;
      rd_ack = 1'b1;
      if (sw) begin              // R4 low lane first
        exp_b[fill_pos] = d[7:0]; fill_pos++;
        if (fill_pos < n) begin exp_b[fill_pos] = d[15:8]; fill_pos++; end
      end else begin
        exp_b[fill_pos] = d[7:0]; fill_pos++;
      end
      tick();
      rd_ack = 1'b0;
      rd_data = 16'($urandom);
    end
    chk(fill_done && wr_req && !rd_req, "R6 fill_done with wr_req", {fill_done, wr_req, rd_req}, 3'b110);
    chk(fill_pos == n, "R4 bytes filled", fill_pos, n);
    m = 0;
    for (int k = 0; k < nwr; k++) begin
      int w = $urandom_range(0, 2);
      for (int j = 0; j < w; j++) begin
        if (stray) begin rd_ack = 1'b1; rd_data = 16'($urandom); end  // R9
        tick();
        rd_ack = 1'b0;
      end
      if (dw && (n - m) >= 2) begin
        ed = {exp_b[m+1], exp_b[m]}; eb = 2'b11; m += 2;
      end else begin
        ed = {8'h00, exp_b[m]}; eb = 2'b01; m += 1;
      end
      chk(wr_req && !fill_done || (k == 0 && w == 0), "R6 pulse width", fill_done, 0);
      chk(wr_req && wr_data == ed, "R7 write data", wr_data, ed);
      chk(wr_be == eb, "R7 byte enables", wr_be, eb);
      chk(!drain_done, "R8 no early drain_done", drain_done, 0);
      wr_ack = 1'b1;
      tick();
      wr_ack = 1'b0;
    end
    chk(drain_done && !busy && !wr_req, "R8 drain_done idle", {drain_done, busy, wr_req}, 3'b100);
    tick();
    chk(!drain_done && !busy && wr_be == 2'b00, "R8 pulse one clock", drain_done, 0);
  endtask

  initial begin
    void'($urandom(32'd24601));
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R10 reset state
    chk(!busy && !rd_req && !wr_req && !fill_done && !drain_done, "R10 idle outputs",
        {busy, rd_req, wr_req, fill_done, drain_done}, 0);
    chk(rd_cycles == 0 && wr_cycles == 0 && wr_be == 0, "R10 counts zero",
        {rd_cycles, wr_cycles, wr_be}, 0);
    // R9 acks while idle do nothing
    rd_ack = 1'b1; wr_ack = 1'b1; tick(); rd_ack = 1'b0; wr_ack = 1'b0;
    chk(!busy && !fill_done && !drain_done, "R9 idle acks", busy, 0);
    // R11 8-bit requester source to 16-bit target, four bytes
    run_pass(4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(1, "R11 four reads two writes", 0, 0);
    // R5 direction swapped: target 8-bit is source
    run_pass(4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R1 zero count
    run_pass(0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // odd tails
    run_pass(3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_pass(1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_pass(3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    // R1 start while busy
    run_pass(500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 160; i++) begin
      int bl;
      bl = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 2000) : $urandom_range(1, 4);
      run_pass(bl, 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), ($urandom_range(0, 7) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule